// File: doc/BRIEF.md
# Multi-channel DMA control register bank

This block is the register front end for a bank of DMA channels. A single 32-bit register bus reaches every channel through one address window. Each channel takes a fixed 128-byte slice of that window, so the channel number is the address above bit 7 and the word register is address bits 6:2. For each channel the block holds a 16-bit status word and five 32-bit pointer and select registers. It applies masked control writes to the status word and exposes status and the low command pointer of every channel to the descriptor executor.

A control write sets or clears the run, pause, flush and wake bits and the device status byte through a write mask. Starting a channel raises its active bit. Any control write that leaves a channel active starts a scanner. The scanner walks all channels in index order, one per cycle, and gives a one-cycle start strobe to each channel that is running, active and not reported busy by the executor. A control write that leaves the flush bit set gives that channel a one-cycle flush strobe.

Top module: `dma_chan_regbank`

## Requirements
- R1: A byte address selects channel `addr_i[ADDR_W-1:7]` and word index `addr_i[6:2]`. Word indices 2 (command pointer high), 3 (command pointer low), 4 (interrupt select), 5 (branch select) and 6 (wait select) store all 32 written bits. A read returns the data on `rdata_o` with `rvalid_o` high in the cycle after the request. `cmd_ptr_o` carries each channel's command pointer low register.
- R2: Reading word index 0 or 1 returns the status word in bits 15:0, with zeros above. Writes to index 1 have no effect. Indices 7 to 31 read as zero, and writes to them have no effect.
- R3: A write to index 0 is a control write. Bits 31:16 are a mask and bits 15:0 are the values. Only masked bits in positions 15:12 and 7:0 take the new value. Status bits 11:8 cannot be written this way.
- R4: The status bits are: 15 run, 14 pause, 13 flush, 12 wake, 11 dead, 10 active, 8 branch-taken, 7:0 device status. A control write that sets run also sets active and clears dead. One that clears run also clears active. `status_o` shows each channel's status word.
- R5: A write to the command pointer low register is ignored while the channel's active bit is set. The command pointer high register stays writable.
- R6: `flush_o[ch]` pulses for exactly the one cycle after a control write to that channel whose resulting status has flush set. No other write pulses it.
- R7: A control write that leaves its channel active starts a scan. In the cycles after the write, the scan visits channels 0 to NUM_CH-1, one per cycle. It pulses `start_o[ch]` when that channel has run and active set and `busy_i[ch]` is low. At most one start bit is high in any cycle. A control write that leaves the channel inactive starts no scan.
- R8: If a scan is already running when a new scan request arrives, one more full scan follows the current one.
- R9: Reset clears every register of every channel, with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address within the channel window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| busy_i | input | NUM_CH | Executor reports a channel busy with a transfer |
| status_o | output | NUM_CH*16 | Status word per channel |
| cmd_ptr_o | output | NUM_CH*32 | Command pointer low per channel |
| flush_o | output | NUM_CH | Flush strobe per channel |
| start_o | output | NUM_CH | Start strobe per channel |

## Verification
The bench builds the block with NUM_CH = 4. At that size a full sweep over every channel and all 32 word indices, both stored and reserved, costs only a few hundred cycles, so every decode cell is written and read back. Four channels also allow exact cycle positions for scan strobes and a back-to-back pair of control writes that requests a second scan. They also allow busy and idle channels to be mixed within one scan.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned STAT_W = 16;

  localparam logic [IDX_W-1:0] IDX_CTRL = 5'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 5'd1;
  localparam logic [IDX_W-1:0] IDX_CPH  = 5'd2;
  localparam logic [IDX_W-1:0] IDX_CPL  = 5'd3;
  localparam logic [IDX_W-1:0] IDX_INTS = 5'd4;
  localparam logic [IDX_W-1:0] IDX_BRS  = 5'd5;
  localparam logic [IDX_W-1:0] IDX_WTS  = 5'd6;

  localparam int unsigned B_RUN   = 15;
  localparam int unsigned B_PAUSE = 14;
  localparam int unsigned B_FLUSH = 13;
  localparam int unsigned B_WAKE  = 12;
  localparam int unsigned B_DEAD  = 11;
  localparam int unsigned B_ACT   = 10;
  localparam int unsigned B_BT    = 8;

  localparam logic [STAT_W-1:0] CTRL_WMASK = 16'hF0FF;

  // masked control update with run side effects
  function automatic logic [STAT_W-1:0] ctrl_update(logic [STAT_W-1:0] cur,
                                                    logic [31:0] w);
    logic [STAT_W-1:0] m, n;
    m = w[31:16] & CTRL_WMASK;
    n = (cur & ~m) | (w[15:0] & m);
    if (m[B_RUN]) begin
      n[B_ACT] = w[B_RUN];
      if (w[B_RUN]) n[B_DEAD] = 1'b0;
    end
    return n;
  endfunction
endpackage

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
  import dma_rb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [STAT_W-1:0] status_o,
  output logic [31:0]       cmd_lo_o,
  output logic              flush_o,
  output logic              kick_o
);
  logic [STAT_W-1:0] stat_q, stat_nx;
  logic [31:0] cph_q, cpl_q, ints_q, brs_q, wts_q;
  logic flush_q;

  assign stat_nx = ctrl_update(stat_q, wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      cph_q   <= '0;
      cpl_q   <= '0;
      ints_q  <= '0;
      brs_q   <= '0;
      wts_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      if (wr_i) begin
        unique case (idx_i)
          IDX_CTRL: begin
            stat_q  <= stat_nx;
            flush_q <= stat_nx[B_FLUSH];
          end
          IDX_CPH:  cph_q <= wdata_i;
          IDX_CPL:  if (!stat_q[B_ACT]) cpl_q <= wdata_i;
          IDX_INTS: ints_q <= wdata_i;
          IDX_BRS:  brs_q <= wdata_i;
          IDX_WTS:  wts_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_CTRL, IDX_STAT: rdata_o = {16'h0, stat_q};
      IDX_CPH:  rdata_o = cph_q;
      IDX_CPL:  rdata_o = cpl_q;
      IDX_INTS: rdata_o = ints_q;
      IDX_BRS:  rdata_o = brs_q;
      IDX_WTS:  rdata_o = wts_q;
      default:  rdata_o = '0;
    endcase
  end

  assign kick_o   = wr_i && (idx_i == IDX_CTRL) && stat_nx[B_ACT];
  assign status_o = stat_q;
  assign cmd_lo_o = cpl_q;
  assign flush_o  = flush_q;
endmodule

// File: rtl/dma_rb_scan.sv
module dma_rb_scan #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kick_i,
  input  logic [NUM_CH-1:0] ready_i,
  output logic [NUM_CH-1:0] start_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  logic            scan_q, pend_q;
  logic [CH_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else if (!scan_q) begin
      if (kick_i) begin
        scan_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (idx_q == LAST) begin
      // a request seen during the pass buys one more pass
      idx_q  <= '0;
      pend_q <= 1'b0;
      if (!(pend_q || kick_i)) scan_q <= 1'b0;
    end else begin
      idx_q  <= idx_q + 1'b1;
      pend_q <= pend_q | kick_i;
    end
  end

  always_comb begin
    start_o = '0;
    if (scan_q && ready_i[idx_q]) start_o[idx_q] = 1'b1;
  end
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
  import dma_rb_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ADDR_W = CH_W + 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output logic                     rvalid_o,
  input  logic [NUM_CH-1:0]        busy_i,
  output logic [NUM_CH*STAT_W-1:0] status_o,
  output logic [NUM_CH*32-1:0]     cmd_ptr_o,
  output logic [NUM_CH-1:0]        flush_o,
  output logic [NUM_CH-1:0]        start_o
);
  logic [CH_W-1:0]  sel_ch;
  logic [IDX_W-1:0] widx;
  logic             ch_hit;
  logic             unused_lsb;
  logic [31:0]      ch_rdata [NUM_CH];
  logic [NUM_CH-1:0] kick_v, ready_v;
  logic [31:0]      rdata_q;
  logic             rvalid_q;

  assign sel_ch     = addr_i[ADDR_W-1:7];
  assign widx       = addr_i[6:2];
  assign ch_hit     = 32'(sel_ch) < NUM_CH;
  assign unused_lsb = ^addr_i[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_g;
    assign wr_g = req_i && we_i && ch_hit && (sel_ch == CH_W'(g));

    dma_rb_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_g),
      .idx_i    (widx),
      .wdata_i  (wdata_i),
      .rdata_o  (ch_rdata[g]),
      .status_o (status_o[g*STAT_W +: STAT_W]),
      .cmd_lo_o (cmd_ptr_o[g*32 +: 32]),
      .flush_o  (flush_o[g]),
      .kick_o   (kick_v[g])
    );

    assign ready_v[g] = status_o[g*STAT_W + B_RUN] && status_o[g*STAT_W + B_ACT]
                        && !busy_i[g];
  end

  dma_rb_scan #(.NUM_CH(NUM_CH)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_i  (|kick_v),
    .ready_i (ready_v),
    .start_o (start_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= ch_hit ? ch_rdata[sel_ch] : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/dma_rb_chk.sv
module dma_rb_chk #(
  parameter int unsigned NUM_CH = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic                rvalid_o,
  input logic [NUM_CH-1:0]   busy_i,
  input logic [NUM_CH*16-1:0] status_o,
  input logic [NUM_CH*32-1:0] cmd_ptr_o,
  input logic [NUM_CH-1:0]   flush_o,
  input logic [NUM_CH-1:0]   start_o
);
  logic [NUM_CH-1:0] rdy;
  always_comb
    for (int i = 0; i < NUM_CH; i++)
      rdy[i] = status_o[i*16+15] && status_o[i*16+10] && !busy_i[i];

  a_r1_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  a_r7_start_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));

  a_r7_start_only_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o & ~rdy) == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [15:0] st;
    assign st = status_o[g*16 +: 16];

    a_r4_active_tracks_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st[10] == st[15]);

    a_r3_locked_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !st[11] && !st[9] && !st[8]);

    a_r5_cmdlo_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st[10] |=> $stable(cmd_ptr_o[g*32 +: 32]));

    a_r6_flush_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o[g] |-> st[13]);

    a_r6_flush_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o[g] |-> $past(req_i && we_i));
  end
endmodule

bind dma_chan_regbank dma_rb_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/dma_chan_regbank_tb_top.sv
module dma_chan_regbank_tb_top;
  localparam int NCH = 4;
  localparam int AW = 9;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic rvalid_o;
  logic [NCH-1:0] busy_i = '1;
  logic [NCH*16-1:0] status_o;
  logic [NCH*32-1:0] cmd_ptr_o;
  logic [NCH-1:0] flush_o, start_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int wr_cyc;
  int start_cnt[NCH], start_cyc[NCH], flush_cnt[NCH], flush_cyc[NCH];
  logic [15:0] exp_st[NCH];

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  dma_chan_regbank #(.NUM_CH(NCH)) dut_i (.*);

  always @(negedge clk_i)
    for (int i = 0; i < NCH; i++) begin
      if (start_o[i]) begin start_cnt[i]++; start_cyc[i] = cyc; end
      if (flush_o[i]) begin flush_cnt[i]++; flush_cyc[i] = cyc; end
    end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    for (int i = 0; i < NCH; i++) begin
      start_cnt[i] = 0; start_cyc[i] = -1; flush_cnt[i] = 0; flush_cyc[i] = -1;
    end
  endtask

  task automatic wr(input int ch, input int idx, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = AW'((ch << 7) | (idx << 2)); wdata_i = d;
    @(posedge clk_i);
    #1;
    wr_cyc = cyc;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input int ch, input int idx, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'((ch << 7) | (idx << 2));
    @(posedge clk_i);
    #1;
    req_i = 1'b0;
    @(negedge clk_i);
    d = rvalid_o ? rdata_o : 32'hDEAD_BEEF;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [31:0] pat(input int ch, input int idx);
    return 32'h5A00_0000 | 32'(ch << 16) | 32'(idx << 8) | 32'(ch * 7 + idx);
  endfunction

  function automatic logic [15:0] mdl(input logic [15:0] cur, input logic [31:0] w);
    logic [15:0] m, n;
    m = w[31:16] & 16'hF0FF;
    n = (cur & ~m) | (w[15:0] & m);
    if (w[31]) begin
      if (w[15]) n = (n | 16'h0400) & ~16'h0800;
      else       n = n & ~16'h0400;
    end
    return n;
  endfunction

  task automatic ctl(input int ch, input logic [31:0] w);
    exp_st[ch] = mdl(exp_st[ch], w);
    wr(ch, 0, w);
  endtask

  function automatic logic [31:0] exp_rd(input int ch, input int idx);
    if (idx <= 1) return {16'h0, exp_st[ch]};
    if (idx <= 6) return pat(ch, idx);
    return 32'h0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] wlist [9];
    wlist = '{32'h00FF_00A5, 32'h4000_4000, 32'h0F00_0F00, 32'h8000_8000,
              32'h00FF_0000, 32'h8000_0000, 32'h1000_1000, 32'h0000_FFFF,
              32'hF0FF_0000};
    for (int i = 0; i < NCH; i++) exp_st[i] = '0;
    clr_mon();
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R9 reset state
    chk(status_o == '0, "R9 status_o", status_o[31:0], 0);
    chk(cmd_ptr_o == '0, "R9 cmd_ptr_o", cmd_ptr_o[31:0], 0);
    chk(start_o == '0 && flush_o == '0 && !rvalid_o, "R9 strobes",
        {start_o, flush_o}, 0);
    for (int c = 0; c < NCH; c++)
      for (int x = 0; x < 32; x++) begin
        rd(c, x, d);
        chk(d == 0, $sformatf("R9 reset read ch%0d idx%0d", c, x), d, 0);
      end

    // R1 R2 write sweep over every index, control excluded
    for (int c = 0; c < NCH; c++)
      for (int x = 1; x < 32; x++)
        wr(c, x, (x >= 2 && x <= 6) ? pat(c, x) : 32'hFFFF_FFFF);
    for (int c = 0; c < NCH; c++) begin
      for (int x = 0; x < 32; x++) begin
        rd(c, x, d);
        chk(d == exp_rd(c, x), $sformatf("R1/R2 read ch%0d idx%0d", c, x), d, exp_rd(c, x));
      end
      chk(cmd_ptr_o[c*32 +: 32] == pat(c, 3), "R1 cmd_ptr_o", cmd_ptr_o[c*32 +: 32], pat(c, 3));
      chk(status_o[c*16 +: 16] == 16'h0, "R2 status write ignored", status_o[c*16 +: 16], 0);
    end

    // R3 R4 masked control sequence on channel 1
    foreach (wlist[k]) begin
      ctl(1, wlist[k]);
      chk(status_o[31:16] == exp_st[1], $sformatf("R3/R4 status_o step %0d", k),
          status_o[31:16], exp_st[1]);
      rd(1, 0, d);
      chk(d == {16'h0, exp_st[1]}, "R2 control index reads status", d, exp_st[1]);
      rd(1, 1, d);
      chk(d == {16'h0, exp_st[1]}, "R3 status read", d, exp_st[1]);
    end

    // R5 command pointer low locked while active
    wr(2, 3, 32'h1111_1111);
    ctl(2, 32'h8000_8000);
    wr(2, 3, 32'h2222_2222);
    rd(2, 3, d);
    chk(d == 32'h1111_1111, "R5 cmd low blocked", d, 32'h1111_1111);
    chk(cmd_ptr_o[95:64] == 32'h1111_1111, "R5 cmd_ptr_o held", cmd_ptr_o[95:64], 32'h1111_1111);
    wr(2, 2, 32'h3333_3333);
    rd(2, 2, d);
    chk(d == 32'h3333_3333, "R5 cmd high writable", d, 32'h3333_3333);
    ctl(2, 32'h8000_0000);
    wr(2, 3, 32'h4444_4444);
    rd(2, 3, d);
    chk(d == 32'h4444_4444, "R5 cmd low after stop", d, 32'h4444_4444);

    // R6 flush strobe
    clr_mon();
    ctl(0, 32'h2000_2000);
    idle(3);
    chk(flush_cnt[0] == 1, "R6 flush count", flush_cnt[0], 1);
    chk(flush_cyc[0] == wr_cyc, "R6 flush cycle", flush_cyc[0], wr_cyc);
    chk(flush_cnt[1] + flush_cnt[2] + flush_cnt[3] == 0, "R6 other flush", flush_cnt[1], 0);
    ctl(0, 32'h0010_0010);
    idle(2);
    chk(flush_cnt[0] == 2, "R6 flush kept set", flush_cnt[0], 2);
    ctl(0, 32'h2010_0000);
    wr(0, 3, 32'h0);
    idle(2);
    chk(flush_cnt[0] == 2, "R6 no flush when cleared", flush_cnt[0], 2);

    // R7 scan order and eligibility
    busy_i = '0;
    clr_mon();
    ctl(3, 32'h8000_8000);
    idle(10);
    chk(start_cnt[3] == 1, "R7 start count ch3", start_cnt[3], 1);
    chk(start_cyc[3] == wr_cyc + 3, "R7 start cycle ch3", start_cyc[3], wr_cyc + 3);
    chk(start_cnt[0] + start_cnt[1] + start_cnt[2] == 0, "R7 idle channels", start_cnt[0], 0);
    busy_i = 4'b0010;
    clr_mon();
    ctl(1, 32'h8000_8000);
    idle(10);
    chk(start_cnt[1] == 0, "R7 busy not started", start_cnt[1], 0);
    chk(start_cnt[3] == 1, "R7 rescan ch3", start_cnt[3], 1);
    clr_mon();
    ctl(0, 32'h0000_0000);
    idle(10);
    chk(start_cnt[3] == 0, "R7 inactive write no scan", start_cnt[3], 0);

    // R8 request during a scan adds a pass
    clr_mon();
    ctl(0, 32'h8000_8000);
    ctl(2, 32'h8000_8000);
    idle(15);
    chk(start_cnt[0] == 2, "R8 ch0 starts", start_cnt[0], 2);
    chk(start_cnt[2] == 2, "R8 ch2 starts", start_cnt[2], 2);
    chk(start_cnt[3] == 2, "R8 ch3 starts", start_cnt[3], 2);
    chk(start_cnt[1] == 0, "R8 ch1 busy", start_cnt[1], 0);
    for (int c = 0; c < NCH; c++)
      chk(status_o[c*16 +: 16] == exp_st[c], "R4 final status", status_o[c*16 +: 16], exp_st[c]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule